// File: doc/BRIEF.md
# Threshold Neuron with Inhibit

This block is a single-bit digital neuron. Five excitatory lines are counted. When at least three of them are high and the active-low inhibit line is high, the neuron wants to fire. A registered output bit takes that decision on a rising clock edge, but only while the capture enable is high. While the enable is low, the output keeps its last value. The decision depends only on the inputs present at the latest capturing edge. Inputs from earlier edges have no effect.

A clock cycle is a low phase followed by a high phase, and the output takes its new value at the rising edge that ends the low phase. The neuron can be cleared in two ways. The first is to hold the capture enable high with every other input low for one edge. The second is the synchronous active-low reset, which has priority over everything else. The input count and the firing threshold are parameters, with defaults of five and three.

Top module: `spike_neuron`

## Requirements
- R1: When `rst_n` is low at a rising edge, `spike_q` is 0 after that edge.
- R2: With `rst_n`=1, `capture_en`=1 and `inhibit_n`=1 at a rising edge, `spike_q` becomes 1 after that edge when the number of ones in `exc_in` is 3 or more. Otherwise it becomes 0. Bit 0 of `exc_in` is input A and bit 4 is input E, and the count does not depend on which bits are set.
- R3: With `rst_n`=1, `capture_en`=1 and `inhibit_n`=0 at a rising edge, `spike_q` becomes 0 whatever `exc_in` holds.
- R4: With `rst_n`=1 and `capture_en`=0 at a rising edge, `spike_q` keeps its previous value. This also holds when `exc_in`=5'b11111 and `inhibit_n`=1.
- R5: A capture with `exc_in`=0 and `inhibit_n`=0 clears `spike_q` to 0.
- R6: There is no accumulation. After a firing capture, a capture with fewer than 3 ones in `exc_in` gives `spike_q`=0.
- R7: At the threshold boundary with `inhibit_n`=1, exactly 2 ones never fire and exactly 3 ones always fire.
- R8: `rst_n` low has priority over `capture_en`. A reset edge whose inputs would make the neuron fire still gives `spike_q`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; capture on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_in | input | NUM_EXC (5) | Excitatory inputs, bit 0 = A through bit 4 = E |
| inhibit_n | input | 1 | Active-low inhibit; 0 suppresses firing |
| capture_en | input | 1 | 1 captures the fire decision, 0 holds the output |
| spike_q | output | 1 | Registered fire output |

## Verification
The hardest case to reach is a hold with a firing input pattern. This needs `spike_q` to already be 0 through a capture, not through reset. Then `capture_en` must be dropped while all five lines and the inhibit are high. The bench builds this by first capturing an all-zero, inhibited input, then holding full excitation for several edges with the enable low. It also holds a 1 while presenting patterns that would clear it. The threshold boundary is covered by sweeping all 32 patterns with the inhibit released and again with it applied. A fixed-seed random mix of enable, inhibit and reset toggling follows the sweeps.

// File: rtl/neuron_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the threshold neuron.
// Assumes: counts are unsigned and fit in 32 bits.
package neuron_pkg;
    // Width needed to hold a count from 0 to n inclusive.
    function automatic int count_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/ones_counter.sv
`timescale 1ns/1ps
// Module: ones_counter
// Counts the set bits of a vector with a ripple chain of partial sums.
// Assumes: N >= 1; the output width comes from neuron_pkg::count_width.
module ones_counter #(
    parameter int N  = 5,
    parameter int CW = neuron_pkg::count_width(N)
) (
    input  logic [N-1:0]  bits_in,
    output logic [CW-1:0] ones
);
    logic [CW-1:0] part [0:N];

    assign part[0] = '0;

    // One adder stage per input bit.
    for (genvar i = 0; i < N; i++) begin : g_stage
        assign part[i+1] = part[i] + CW'(bits_in[i]);
    end

    assign ones = part[N];
endmodule

// File: rtl/fire_decide.sv
`timescale 1ns/1ps
// Module: fire_decide
// Turns a ones count and an active-low inhibit into a fire decision.
// Assumes: THRESH is at most N; a threshold of 0 always fires unless inhibited.
module fire_decide #(
    parameter int N      = 5,
    parameter int THRESH = 3,
    parameter int CW     = neuron_pkg::count_width(N)
) (
    input  logic [CW-1:0] ones,
    input  logic          inhibit_n,
    output logic          fire
);
    logic over;

    if (THRESH <= 0) begin : g_always
        // No count needed; only the inhibit decides.
        assign over = 1'b1;
    end else begin : g_compare
        localparam logic [CW-1:0] LIMIT = CW'(THRESH);
        // Compare the count against the threshold.
        assign over = (ones >= LIMIT);
    end

    // Gate the threshold result with the inhibit line.
    assign fire = over & inhibit_n;
endmodule

// File: rtl/spike_reg.sv
`timescale 1ns/1ps
// Module: spike_reg
// Output flop with a synchronous active-low reset and a capture enable.
// Assumes: reset has priority; the flop holds while the enable is low.
module spike_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);
    // Clear on reset, capture on enable, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/spike_neuron.sv
`timescale 1ns/1ps
// Module: spike_neuron (top)
// Threshold neuron: fires when THRESH or more of NUM_EXC lines are high and
// the inhibit is not applied. The decision is registered only when capture_en is high.
// Assumes: all inputs are synchronous to clk.
module spike_neuron #(
    parameter int NUM_EXC = 5,
    parameter int THRESH  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXC-1:0] exc_in,
    input  logic               inhibit_n,
    input  logic               capture_en,
    output logic               spike_q
);
    localparam int CW = neuron_pkg::count_width(NUM_EXC);

    logic [CW-1:0] ones;
    logic          fire;

    ones_counter #(.N(NUM_EXC), .CW(CW)) u_count (
        .bits_in (exc_in),
        .ones    (ones)
    );

    fire_decide #(.N(NUM_EXC), .THRESH(THRESH), .CW(CW)) u_decide (
        .ones      (ones),
        .inhibit_n (inhibit_n),
        .fire      (fire)
    );

    spike_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (capture_en),
        .d     (fire),
        .q     (spike_q)
    );
endmodule

// File: rtl/spike_neuron_chk.sv
`timescale 1ns/1ps
// Module: spike_neuron_chk
// Checks the port behaviour of spike_neuron; bound to it below.
// Assumes: the same parameters as the top module.
module spike_neuron_chk #(
    parameter int NUM_EXC = 5,
    parameter int THRESH  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EXC-1:0] exc_in,
    input logic               inhibit_n,
    input logic               capture_en,
    input logic               spike_q
);
    // R1 and R8: a reset edge clears the output whatever the other inputs are.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> !spike_q);

    // R2: enough ones with the inhibit released fires.
    p_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && inhibit_n && ($countones(exc_in) >= THRESH)) |=> spike_q);

    // R7: below the threshold there is no fire.
    p_below_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && ($countones(exc_in) < THRESH)) |=> !spike_q);

    // R3: an applied inhibit suppresses firing.
    p_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && !inhibit_n) |=> !spike_q);

    // R4: the output holds while capture is disabled.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en |=> $stable(spike_q));
endmodule

bind spike_neuron spike_neuron_chk #(.NUM_EXC(NUM_EXC), .THRESH(THRESH)) u_chk (.*);

// File: tb/sim_spike_neuron.sv
`timescale 1ns/1ps
// Bench for spike_neuron: directed sweeps plus fixed-seed random stimulus.
module sim_spike_neuron;
    localparam int N  = 5;
    localparam int TH = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] exc_in = '0;
    logic         inhibit_n = 1'b0;
    logic         capture_en = 1'b0;
    logic         spike_q;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    logic model_q = 1'b0;

    spike_neuron #(.NUM_EXC(N), .THRESH(TH)) u0 (.*);

    always #4 clk = ~clk;

    // Expected fire decision computed from the requirements.
    function automatic logic want_fire(input logic [N-1:0] e, input logic inh_n);
        int c = 0;
        for (int k = 0; k < N; k++) c += int'(e[k]);
        return (c >= TH) && inh_n;
    endfunction

    function automatic int ones_of(input logic [N-1:0] e);
        int c = 0;
        for (int k = 0; k < N; k++) c += int'(e[k]);
        return c;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: spike_q=%b expected %b", req, act, exp);
        end
    endtask

    // Drive at the falling edge, update the model, then sample 1 ns after the rising edge.
    task automatic step(input logic r, input logic [N-1:0] e, input logic inh, input logic en);
        @(negedge clk);
        rst_n = r; exc_in = e; inhibit_n = inh; capture_en = en;
        @(posedge clk);
        if (!r)      model_q = 1'b0;
        else if (en) model_q = want_fire(e, inh);
        #1;
    endtask

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd20240611);

        // R1: reset state.
        step(1'b0, '0, 1'b0, 1'b0);
        check("R1", spike_q, 1'b0);

        // R8: reset wins over a firing capture.
        step(1'b1, '1, 1'b1, 1'b1);
        check("R2", spike_q, 1'b1);
        step(1'b0, '1, 1'b1, 1'b1);
        check("R8", spike_q, 1'b0);

        // R2 and R7: sweep all 32 patterns with the inhibit released.
        for (int p = 0; p < 32; p++) begin
            step(1'b1, N'(p), 1'b1, 1'b1);
            if (ones_of(N'(p)) == TH - 1 || ones_of(N'(p)) == TH)
                check("R7", spike_q, model_q);
            else
                check("R2", spike_q, model_q);
        end

        // R3: sweep all 32 patterns with the inhibit applied.
        for (int p = 0; p < 32; p++) begin
            step(1'b1, N'(p), 1'b0, 1'b1);
            check("R3", spike_q, 1'b0);
        end

        // R3: rising excitation while inhibited stays low.
        step(1'b1, 5'b00001, 1'b0, 1'b1); check("R3", spike_q, 1'b0);
        step(1'b1, 5'b00011, 1'b0, 1'b1); check("R3", spike_q, 1'b0);
        step(1'b1, 5'b00111, 1'b0, 1'b1); check("R3", spike_q, 1'b0);
        step(1'b1, 5'b11111, 1'b0, 1'b1); check("R3", spike_q, 1'b0);

        // R6: fire, then a weak pattern clears without memory.
        step(1'b1, 5'b11111, 1'b1, 1'b1); check("R2", spike_q, 1'b1);
        step(1'b1, 5'b00011, 1'b1, 1'b1); check("R6", spike_q, 1'b0);

        // R5 then R4: clear by capture, then hold 0 under full excitation.
        step(1'b1, 5'b11111, 1'b1, 1'b1);
        step(1'b1, '0, 1'b0, 1'b1);       check("R5", spike_q, 1'b0);
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 5'b11111, 1'b1, 1'b0);
            check("R4", spike_q, 1'b0);
        end

        // R4: hold a 1 against patterns that would clear it.
        step(1'b1, 5'b10101, 1'b1, 1'b1); check("R2", spike_q, 1'b1);
        step(1'b1, 5'b00000, 1'b1, 1'b0); check("R4", spike_q, 1'b1);
        step(1'b1, 5'b11111, 1'b0, 1'b0); check("R4", spike_q, 1'b1);

        // Random mix checked against the model.
        for (int k = 0; k < 400; k++) begin
            logic r, inh, en;
            logic [N-1:0] e;
            r   = ($urandom % 16) != 0;
            inh = ($urandom % 4) != 0;
            en  = ($urandom % 3) != 0;
            e   = N'($urandom);
            step(r, e, inh, en);
            if (!r)        check("R1", spike_q, model_q);
            else if (!en)  check("R4", spike_q, model_q);
            else if (!inh) check("R3", spike_q, model_q);
            else           check("R2", spike_q, model_q);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule